// File: doc/BRIEF.md
# Oversampling Serial Byte Receiver

This block turns an asynchronous serial line into bytes. The line rests high. A frame is a low start bit, then eight data bits with the most significant bit first, then at least one high stop bit. The receiver runs on a clock at four times the bit rate, so each bit lasts exactly four clock periods. The line first passes through a synchroniser. A falling level seen while the block is idle starts a frame. Each bit is then read once, at a fixed phase inside its four-clock window. If the start bit reads high at its own sample point, the block treats the low level as a glitch and drops back to idle.

A finished byte goes into an output holding register and is offered to the consumer on a four-phase valid/acknowledge handshake. `byte_valid` rises and stays high, with `byte_data` frozen, until the consumer raises `byte_ack`. `byte_valid` then falls, and the consumer lowers `byte_ack` to close the exchange. This is the block's back-pressure rule. The receiver cannot stall the serial line. A byte that finishes while `byte_valid` is still high, or while `byte_ack` has not yet been lowered, is discarded, and the outputs keep their values.

Top module: `ovs_byte_rx`

## Requirements
- R1: While `rst_n` is low, and after it is released with the line idle, `byte_valid` is 0 and `byte_data` is 0x00.
- R2: A frame is one low start bit, eight data bits with the most significant bit sent first, and a high stop bit. Each bit is held for four clock periods. The byte presented on `byte_data` equals the eight data bits in the order they were sent.
- R3: Call the first rising clock edge that samples the start bit's low level edge 1. Then `byte_valid` is still low after edge 39 and is high after edge 40.
- R4: A low pulse from idle that lasts one or two clock periods starts no reception. `byte_valid` stays low, and the next well-formed frame is received correctly.
- R5: Once high, `byte_valid` stays high with `byte_data` unchanged for as long as `byte_ack` is low. It falls at the first clock edge that samples `byte_ack` high.
- R6: A completed byte is loaded only when `byte_valid` and `byte_ack` are both low. Otherwise it is dropped, and `byte_data` and `byte_valid` keep their values.
- R7: Frames sent back to back, with a stop bit exactly one bit period long, are all received when the consumer acknowledges promptly.
- R8: Asserting `rst_n` low in the middle of a frame abandons that frame. No byte is presented afterwards, and the next frame is received correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receiver clock, four times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Asynchronous serial line, idle high |
| byte_data | output | 8 | Last accepted byte, held while offered |
| byte_valid | output | 1 | Byte offered to the consumer (four-phase request) |
| byte_ack | input | 1 | Consumer acknowledge (four-phase response) |

## Verification
A bit counter or phase counter that slips by even one step shows up at the ports within a single frame. Either `byte_valid` rises on the wrong edge of the 40-edge frame window, or `byte_data` comes out shifted by one position. Sweeping all 256 byte values back to back exposes a sample point that drifts across frames, and a stop bit that restarts reception, within a few frames. A wrong handshake state shows within one or two cycles of `byte_ack` changing, as a `byte_valid` that does not fall or a held byte that is overwritten.

// File: rtl/ovs_rx_pkg.sv
package ovs_rx_pkg;
  localparam int DATA_BITS_DEF  = 8;
  localparam int OVERSAMPLE_DEF = 4;
  localparam int SAMPLE_PH_DEF  = 1;
  localparam int SYNC_DEPTH_DEF = 2;

  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_BUSY = 1'b1
  } rx_state_e;
endpackage

// File: rtl/ovs_rx_sync.sv
module ovs_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  // Every stage resets to the idle (high) level of the line.
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b1;
          else        chain_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/ovs_rx_frame.sv
module ovs_rx_frame
  import ovs_rx_pkg::*;
#(
  parameter int DATA_BITS  = DATA_BITS_DEF,
  parameter int OVERSAMPLE = OVERSAMPLE_DEF,
  parameter int SAMPLE_PH  = SAMPLE_PH_DEF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line_s,
  output logic                 frame_done,
  output logic [DATA_BITS-1:0] frame_byte
);
  localparam int CYC_W = $clog2(OVERSAMPLE);
  localparam int BIT_W = $clog2(DATA_BITS + 2);
  localparam logic [CYC_W-1:0] CYC_LAST  = CYC_W'(OVERSAMPLE - 1);
  localparam logic [CYC_W-1:0] SAMPLE_AT = CYC_W'(SAMPLE_PH);
  localparam logic [BIT_W-1:0] STOP_IDX  = BIT_W'(DATA_BITS + 1);

  rx_state_e            state_q;
  logic [CYC_W-1:0]     phase_q;
  logic [BIT_W-1:0]     slot_q;
  logic [DATA_BITS-1:0] shift_q;

  logic sample_now, start_glitch, frame_end;

  assign sample_now   = (state_q == RX_BUSY) && (phase_q == SAMPLE_AT);
  assign start_glitch = sample_now && (slot_q == '0) && line_s;
  assign frame_end    = (state_q == RX_BUSY) && (slot_q == STOP_IDX);

  // Frame control: idle -> busy on a low line, busy -> idle at the stop
  // slot or on a start bit that reads high at its sample point.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      phase_q <= '0;
      slot_q  <= '0;
    end else if (state_q == RX_IDLE) begin
      if (!line_s) begin
        state_q <= RX_BUSY;
        phase_q <= '0;
        slot_q  <= '0;
      end
    end else if (frame_end || start_glitch) begin
      state_q <= RX_IDLE;
    end else begin
      phase_q <= (phase_q == CYC_LAST) ? '0 : phase_q + 1'b1;
      if (phase_q == CYC_LAST) slot_q <= slot_q + 1'b1;
    end
  end

  // Bits enter at the low end; the first data bit ends at the top.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          shift_q <= '0;
    else if (sample_now) shift_q <= {shift_q[DATA_BITS-2:0], line_s};
  end

  assign frame_done = frame_end;
  assign frame_byte = shift_q;

  // R2: the slot counter never passes the stop slot
  p_slot_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q <= STOP_IDX);

  // R3: completion is a single-cycle event followed by idle
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (!frame_done && state_q == RX_IDLE));

  // R4: reception only starts from a line sampled low
  p_start_on_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_IDLE && line_s) |=> state_q == RX_IDLE);
endmodule

// File: rtl/ovs_rx_hold.sv
module ovs_rx_hold #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_done,
  input  logic [DATA_BITS-1:0] frame_byte,
  input  logic                 ack,
  output logic                 valid,
  output logic [DATA_BITS-1:0] data
);
  logic accept;
  assign accept = frame_done && !valid && !ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (accept) begin
      valid <= 1'b1;
      data  <= frame_byte;
    end else if (valid && ack) begin
      valid <= 1'b0;
    end
  end

  // R5: offer persists unchanged until acknowledged
  p_hold_until_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ack) |=> (valid && $stable(data)));

  // R5: acknowledge withdraws the offer on the next edge
  p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ack) |=> !valid);

  // R6: no load while either handshake line is high
  p_no_overwrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid || ack) |=> $stable(data));

  // R3: a new offer only follows a completed frame
  p_rise_from_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> $past(frame_done));
endmodule

// File: rtl/ovs_byte_rx.sv
module ovs_byte_rx
  import ovs_rx_pkg::*;
#(
  parameter int DATA_BITS  = DATA_BITS_DEF,
  parameter int OVERSAMPLE = OVERSAMPLE_DEF,
  parameter int SAMPLE_PH  = SAMPLE_PH_DEF,
  parameter int SYNC_DEPTH = SYNC_DEPTH_DEF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_line,
  output logic [DATA_BITS-1:0] byte_data,
  output logic                 byte_valid,
  input  logic                 byte_ack
);
  logic                 line_s;
  logic                 done_w;
  logic [DATA_BITS-1:0] byte_w;

  ovs_rx_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (rx_line),
    .sync_out (line_s)
  );

  ovs_rx_frame #(
    .DATA_BITS  (DATA_BITS),
    .OVERSAMPLE (OVERSAMPLE),
    .SAMPLE_PH  (SAMPLE_PH)
  ) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_s     (line_s),
    .frame_done (done_w),
    .frame_byte (byte_w)
  );

  ovs_rx_hold #(.DATA_BITS(DATA_BITS)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_done (done_w),
    .frame_byte (byte_w),
    .ack        (byte_ack),
    .valid      (byte_valid),
    .data       (byte_data)
  );
endmodule

// File: tb/ovs_byte_rx_tb.sv
`timescale 1ns/1ps
module ovs_byte_rx_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic [7:0] byte_data;
  logic       byte_valid;
  logic       byte_ack;
  logic       auto_ack = 1'b0;
  logic       auto_ack_q = 1'b0;
  logic       man_ack = 1'b0;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  assign byte_ack = auto_ack ? auto_ack_q : man_ack;

  ovs_byte_rx u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_line    (rx_line),
    .byte_data  (byte_data),
    .byte_valid (byte_valid),
    .byte_ack   (byte_ack)
  );

  // Prompt consumer: follows valid half a cycle later.
  always @(negedge clk) auto_ack_q <= byte_valid;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Drives one frame starting at a negedge; ends at a negedge.
  task automatic send(input logic [7:0] b, input bit chk, input string req);
    int edges = 0;
    for (int n = 0; n < 10; n++) begin
      rx_line = (n == 0) ? 1'b0 : (n == 9) ? 1'b1 : b[8 - n];
      for (int c = 0; c < 4; c++) begin
        @(posedge clk);
        edges++;
        @(negedge clk);
        if (chk && edges == 39) check(byte_valid == 1'b0, "R3 early", byte_valid, 0);
        if (chk && edges == 40) begin
          check(byte_valid == 1'b1, "R3 late", byte_valid, 1);
          check(byte_data == b, req, byte_data, b);
        end
      end
    end
  endtask

  task automatic idle(input int n);
    rx_line = 1'b1;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL R3 watchdog actual=%0d expected<100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(byte_valid == 1'b0, "R1 valid in reset", byte_valid, 0);
    rst_n = 1'b1;
    idle(4);
    check(byte_valid == 1'b0, "R1 valid", byte_valid, 0);
    check(byte_data == 8'h00, "R1 data", byte_data, 0);

    // R4: short low pulses from idle
    for (int w = 1; w <= 2; w++) begin
      rx_line = 1'b0;
      for (int i = 0; i < w; i++) @(negedge clk);
      idle(50);
      check(byte_valid == 1'b0, "R4 glitch ignored", byte_valid, 0);
      check(byte_data == 8'h00, "R4 data untouched", byte_data, 0);
    end
    send(8'hA5, 1'b1, "R4 frame after glitch");
    man_ack = 1'b1;
    @(negedge clk);
    check(byte_valid == 1'b0, "R5 ack clears", byte_valid, 0);
    man_ack = 1'b0;
    idle(4);

    // R6 / R5: back-pressure with manual consumer
    send(8'h3C, 1'b1, "R2 first byte");
    send(8'hC3, 1'b0, "R6");
    idle(20);
    check(byte_valid == 1'b1, "R5 held without ack", byte_valid, 1);
    check(byte_data == 8'h3C, "R6 no overwrite while valid", byte_data, 8'h3C);
    man_ack = 1'b1;
    @(negedge clk);
    check(byte_valid == 1'b0, "R5 falls on ack", byte_valid, 0);
    send(8'h81, 1'b0, "R6");
    idle(4);
    check(byte_valid == 1'b0, "R6 dropped while ack high", byte_valid, 0);
    check(byte_data == 8'h3C, "R6 data kept while ack high", byte_data, 8'h3C);
    man_ack = 1'b0;
    idle(2);
    send(8'h5A, 1'b1, "R6 accepted after ack low");
    auto_ack = 1'b1;
    idle(6);
    check(byte_valid == 1'b0, "R5 auto ack", byte_valid, 0);

    // R8: reset in mid-frame
    rx_line = 1'b0;
    repeat (4) @(negedge clk);
    rx_line = 1'b1;
    repeat (6) @(negedge clk);
    rx_line = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    rx_line = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(50);
    check(byte_valid == 1'b0, "R8 no byte after reset", byte_valid, 0);
    check(byte_data == 8'h00, "R8 data cleared", byte_data, 0);
    send(8'hE7, 1'b1, "R8 frame after reset");
    idle(4);

    // R2 / R7: every byte value, frames back to back
    for (int b = 0; b < 256; b++) send(8'(b), 1'b1, "R7 back-to-back sweep");
    idle(8);
    check(byte_valid == 1'b0, "R7 final ack", byte_valid, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule